// File: doc/BRIEF.md
# Configuration Address Translating Bridge

This block is the host-facing end of a configuration-access path. The host programs a 32-bit index register through one 4 KiB window. It then reads or writes a second 4 KiB data window. The block combines the index value with the low bits of the data-window offset to form a flat configuration address, with register, function, device and bus fields. It issues exactly one read or write on a simple request/acknowledge downstream port and completes the host access when the acknowledge arrives.

The index can take three forms. With bit 31 set it passes through almost unchanged. With bit 0 set it is a type-1 style address that keeps the upper bits. Otherwise, the device is given as a one-hot select line, and the block converts the position of that line into a binary device number. Separately, the block routes the four interrupt pins of each attached slot onto four shared interrupt outputs using a rotating swizzle. Output 0 feeds interrupt-controller input 0x1B, and outputs 1 to 3 feed the next three inputs.

Top module: `cfg_xlate_bridge`

## Requirements
- R1: After reset the index register is zero. A host read of the index window at offset 0 returns the index register, and a read at any other index-window offset returns zero. Index-window accesses complete in the cycle they are presented while no downstream transaction is outstanding.
- R2: The index register loads only on an index-window write at offset 0 with all four byte enables set. Index writes at any other offset, or with a partial byte-enable mask, leave it unchanged.
- R3: When index bit 31 is set, the downstream address equals the index ORed with data-window offset bits 1:0.
- R4: When index bit 31 is clear and bit 0 is set, the downstream address is index bits 31:3 followed by data-window offset bits 2:0.
- R5: When index bits 31 and 0 are both clear, the layout of the downstream address is as follows. Bits 2:0 are the data-window offset bits 2:0. Bits 7:3 are index bits 7:3. Bits 10:8 are index bits 10:8 (the function). Bits 15:11 hold the position minus 11 of the lowest set index bit among bits 31..11. Bits 31:16 are zero.
- R6: In the R5 form with no index bit among 31..11 set, downstream address bits 31:11 are all ones. Bits 10:0 are formed as in R5.
- R7: A data-window access raises cfgReq in the cycle after it is presented. The downstream address, write flag, byte enables and write data stay stable while cfgReq is high, until cfgAck. The byte enables and write data equal the host's values.
- R8: A data-window access completes (hostReady high) only in the cycle cfgAck is high. For a read, hostRdata equals cfgRdata in that cycle. After the acknowledge, cfgReq falls in the next cycle.
- R9: Only one downstream transaction is outstanding at a time. While cfgReq is high and cfgAck is low, hostReady stays low for every host access. A data access with a responder delay of d cycles is stalled for d+1 sampled cycles.
- R10: Each slot s, with device number FIRST_DEV+s, drives pins p=0..3 through slotIrq[4*s+p]. Output irqOut[(p + FIRST_DEV + s) mod 4] is the OR of all pins that map to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access request, held until hostReady |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSel | input | 1 | 0 = index window, 1 = data window |
| hostAddr | input | WIN_W | Byte offset inside the selected window |
| hostBe | input | 4 | Byte enables, little-endian lanes |
| hostWdata | input | 32 | Host write data |
| hostReady | output | 1 | Host access completes this cycle |
| hostRdata | output | 32 | Host read data, valid with hostReady |
| cfgReq | output | 1 | Downstream configuration request |
| cfgWrite | output | 1 | Downstream write flag |
| cfgAddr | output | 32 | Translated configuration address |
| cfgBe | output | 4 | Downstream byte enables |
| cfgWdata | output | 32 | Downstream write data |
| cfgAck | input | 1 | Downstream acknowledge |
| cfgRdata | input | 32 | Downstream read data, valid with cfgAck |
| slotIrq | input | 4*NUM_SLOTS | Interrupt pins, four per slot |
| irqOut | output | 4 | Swizzled interrupt lines to controller inputs 0x1B..0x1E |

## Verification
The hardest case to reach from the ports is the one-hot decode: the device number comes from the lowest set bit, so any higher set bits must not affect it. Reaching that case needs index values with several select bits set at once. The stimulus therefore builds one-hot indices with random extra bits above the chosen lowest bit and mixes in the all-clear case. Long responder delays are also drawn, so the stall and hold behaviour is exercised over many cycles rather than only with an immediate acknowledge.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} ctlState_t;

  typedef struct packed {
    logic loadIndex;
    logic launch;
  } ctlStrobe_t;

  // Build the flat configuration address from the index and window offset.
  function automatic logic [31:0] xlateAddr(input logic [31:0] idx, input logic [2:0] off);
    logic [31:0] res;
    logic [4:0]  dev;
    logic        found;
    res   = '0;
    dev   = '0;
    found = 1'b0;
    if (idx[31]) begin
      res = idx | {30'b0, off[1:0]};
    end else if (idx[0]) begin
      res = {idx[31:3], off};
    end else begin
      for (int b = 30; b >= 11; b--) begin
        if (idx[b]) begin
          dev   = 5'(b - 11);
          found = 1'b1;
        end
      end
      res = {16'b0, dev, idx[10:8], idx[7:3], off};
      if (!found) res[31:11] = '1;
    end
    return res;
  endfunction

endpackage

// File: rtl/cfg_xlate_ctrl.sv
module cfg_xlate_ctrl
  import cfg_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic       hostWrite,
  input  logic       hostSel,
  input  logic       idxWrOk,
  input  logic       cfgAck,
  output logic       hostReady,
  output logic       cfgReq,
  output ctlStrobe_t strobe
);

  ctlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  logic idle;
  assign idle = (state == ST_IDLE);

  always_comb begin
    strobe.loadIndex = idle && hostValid && !hostSel && hostWrite && idxWrOk;
    strobe.launch    = idle && hostValid && hostSel;
    hostReady        = (idle && hostValid && !hostSel) || (!idle && cfgAck);
    cfgReq           = !idle;
    stateNext        = state;
    if (strobe.launch)     stateNext = ST_BUSY;
    else if (!idle && cfgAck) stateNext = ST_IDLE;
  end

endmodule

// File: rtl/cfg_xlate_dpath.sv
module cfg_xlate_dpath
  import cfg_xlate_pkg::*;
#(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             hostSel,
  input  logic             hostWrite,
  input  logic [WIN_W-1:0] hostAddr,
  input  logic [3:0]       hostBe,
  input  logic [31:0]      hostWdata,
  input  logic [31:0]      cfgRdata,
  output logic             idxWrOk,
  output logic [31:0]      hostRdata,
  output logic             cfgWrite,
  output logic [31:0]      cfgAddr,
  output logic [3:0]       cfgBe,
  output logic [31:0]      cfgWdata
);

  logic [31:0] indexReg;
  logic        atZero;

  assign atZero  = (hostAddr == '0);
  assign idxWrOk = atZero && (hostBe == 4'hF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= '0;
      cfgWrite <= 1'b0;
      cfgAddr  <= '0;
      cfgBe    <= '0;
      cfgWdata <= '0;
    end else begin
      if (strobe.loadIndex) indexReg <= hostWdata;
      if (strobe.launch) begin
        cfgWrite <= hostWrite;
        cfgAddr  <= xlateAddr(indexReg, hostAddr[2:0]);
        cfgBe    <= hostBe;
        cfgWdata <= hostWdata;
      end
    end
  end

  always_comb begin
    if (hostSel)     hostRdata = cfgRdata;
    else if (atZero) hostRdata = indexReg;
    else             hostRdata = '0;
  end

endmodule

// File: rtl/cfg_irq_swizzle.sv
module cfg_irq_swizzle #(
  parameter int NUM_SLOTS = 4,
  parameter int FIRST_DEV = 11
) (
  input  logic [4*NUM_SLOTS-1:0] slotIrq,
  output logic [3:0]             irqOut
);

  localparam int LANES = 4;

  logic [NUM_SLOTS-1:0] laneHits [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      // Pin p of slot s lands on lane k when (p + dev) mod 4 == k.
      localparam int PIN = (k - ((FIRST_DEV + s) % LANES) + LANES) % LANES;
      assign laneHits[k][s] = slotIrq[LANES*s + PIN];
    end
    assign irqOut[k] = |laneHits[k];
  end

endmodule

// File: rtl/cfg_xlate_bridge.sv
module cfg_xlate_bridge
  import cfg_xlate_pkg::*;
#(
  parameter int WIN_W     = 12,
  parameter int NUM_SLOTS = 4,
  parameter int FIRST_DEV = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostValid,
  input  logic                   hostWrite,
  input  logic                   hostSel,
  input  logic [WIN_W-1:0]       hostAddr,
  input  logic [3:0]             hostBe,
  input  logic [31:0]            hostWdata,
  output logic                   hostReady,
  output logic [31:0]            hostRdata,
  output logic                   cfgReq,
  output logic                   cfgWrite,
  output logic [31:0]            cfgAddr,
  output logic [3:0]             cfgBe,
  output logic [31:0]            cfgWdata,
  input  logic                   cfgAck,
  input  logic [31:0]            cfgRdata,
  input  logic [4*NUM_SLOTS-1:0] slotIrq,
  output logic [3:0]             irqOut
);

  ctlStrobe_t strobe;
  logic       idxWrOk;

  cfg_xlate_ctrl ctlI (
    .clk       (clk),
    .rstN      (rstN),
    .hostValid (hostValid),
    .hostWrite (hostWrite),
    .hostSel   (hostSel),
    .idxWrOk   (idxWrOk),
    .cfgAck    (cfgAck),
    .hostReady (hostReady),
    .cfgReq    (cfgReq),
    .strobe    (strobe)
  );

  cfg_xlate_dpath #(.WIN_W(WIN_W)) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostSel   (hostSel),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .hostBe    (hostBe),
    .hostWdata (hostWdata),
    .cfgRdata  (cfgRdata),
    .idxWrOk   (idxWrOk),
    .hostRdata (hostRdata),
    .cfgWrite  (cfgWrite),
    .cfgAddr   (cfgAddr),
    .cfgBe     (cfgBe),
    .cfgWdata  (cfgWdata)
  );

  cfg_irq_swizzle #(.NUM_SLOTS(NUM_SLOTS), .FIRST_DEV(FIRST_DEV)) swzI (
    .slotIrq (slotIrq),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/cfg_xlate_checker.sv
module cfg_xlate_checker #(
  parameter int WIN_W     = 12,
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   hostValid,
  input logic                   hostWrite,
  input logic                   hostSel,
  input logic [WIN_W-1:0]       hostAddr,
  input logic [3:0]             hostBe,
  input logic                   hostReady,
  input logic [31:0]            hostRdata,
  input logic                   cfgReq,
  input logic                   cfgWrite,
  input logic [31:0]            cfgAddr,
  input logic [3:0]             cfgBe,
  input logic [31:0]            cfgWdata,
  input logic                   cfgAck,
  input logic [31:0]            cfgRdata,
  input logic [4*NUM_SLOTS-1:0] slotIrq,
  input logic [3:0]             irqOut,
  input logic [31:0]            indexReg
);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && !cfgAck |=> cfgReq && $stable(cfgAddr) && $stable(cfgWdata)
                          && $stable(cfgBe) && $stable(cfgWrite));

  assert_read_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostReady && hostSel |-> cfgAck && (hostRdata == cfgRdata));

  assert_drop_after_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && cfgAck |=> !cfgReq);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && !cfgAck |-> !hostReady);

  assert_index_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(hostValid && hostReady && hostWrite && !hostSel && hostAddr == '0 && hostBe == 4'hF)
    |=> $stable(indexReg));

  assert_irq_any_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|irqOut) == (|slotIrq));

endmodule

bind cfg_xlate_bridge cfg_xlate_checker #(.WIN_W(WIN_W), .NUM_SLOTS(NUM_SLOTS)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .hostValid (hostValid),
  .hostWrite (hostWrite),
  .hostSel   (hostSel),
  .hostAddr  (hostAddr),
  .hostBe    (hostBe),
  .hostReady (hostReady),
  .hostRdata (hostRdata),
  .cfgReq    (cfgReq),
  .cfgWrite  (cfgWrite),
  .cfgAddr   (cfgAddr),
  .cfgBe     (cfgBe),
  .cfgWdata  (cfgWdata),
  .cfgAck    (cfgAck),
  .cfgRdata  (cfgRdata),
  .slotIrq   (slotIrq),
  .irqOut    (irqOut),
  .indexReg  (dpI.indexReg)
);

// File: tb/cfg_xlate_bridge_tb_top.sv
module cfg_xlate_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_W      = 12;
  localparam int NUM_SLOTS  = 4;
  localparam int FIRST_DEV  = 11;
  localparam logic [31:0] RD_KEY = 32'h5A5A_0F0F;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   hostValid = 1'b0;
  logic                   hostWrite = 1'b0;
  logic                   hostSel = 1'b0;
  logic [WIN_W-1:0]       hostAddr = '0;
  logic [3:0]             hostBe = '0;
  logic [31:0]            hostWdata = '0;
  logic                   hostReady;
  logic [31:0]            hostRdata;
  logic                   cfgReq;
  logic                   cfgWrite;
  logic [31:0]            cfgAddr;
  logic [3:0]             cfgBe;
  logic [31:0]            cfgWdata;
  logic                   cfgAck = 1'b0;
  logic [31:0]            cfgRdata = '0;
  logic [4*NUM_SLOTS-1:0] slotIrq = '0;
  logic [3:0]             irqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_xlate_bridge #(.WIN_W(WIN_W), .NUM_SLOTS(NUM_SLOTS), .FIRST_DEV(FIRST_DEV)) dut_i (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostSel(hostSel), .hostAddr(hostAddr), .hostBe(hostBe), .hostWdata(hostWdata),
    .hostReady(hostReady), .hostRdata(hostRdata), .cfgReq(cfgReq), .cfgWrite(cfgWrite),
    .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgWdata(cfgWdata), .cfgAck(cfgAck),
    .cfgRdata(cfgRdata), .slotIrq(slotIrq), .irqOut(irqOut)
  );

  int errors = 0;
  int checks = 0;
  int respDelay = 0;
  int reqStarts = 0;
  int holdErrs = 0;
  logic        seenWrite;
  logic [31:0] seenAddr, seenWdata;
  logic [3:0]  seenBe;
  bit          finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference address translation, written from the requirements.
  function automatic logic [31:0] refAddr(input logic [31:0] idx, input logic [2:0] off);
    logic [31:0] a;
    int pos;
    if (idx[31]) return idx | {30'b0, off[1:0]};
    if (idx[0])  return (idx & 32'hFFFF_FFF8) | {29'b0, off};
    pos = 11;
    while (pos < 32 && !idx[pos]) pos++;
    a = (idx & 32'h0000_07F8) | {29'b0, off};
    if (pos == 32) a |= 32'hFFFF_F800;
    else           a |= 32'(pos - 11) << 11;
    return a;
  endfunction

  function automatic logic [3:0] refIrq(input logic [4*NUM_SLOTS-1:0] pins);
    logic [3:0] e = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < 4; p++)
        if (pins[4*s+p]) e[(p + FIRST_DEV + s) % 4] = 1'b1;
    return e;
  endfunction

  // Downstream responder.
  initial begin
    int waitCnt = 0;
    logic prevReq = 1'b0;
    logic [31:0] firstAddr = '0;
    forever begin
      @(negedge clk);
      if (cfgReq && !prevReq) begin
        reqStarts++;
        firstAddr = cfgAddr;
      end
      if (cfgReq && cfgAddr !== firstAddr) holdErrs++;
      prevReq = cfgReq;
      if (cfgAck) begin
        cfgAck = 1'b0;
      end else if (cfgReq) begin
        if (waitCnt >= respDelay) begin
          cfgAck    = 1'b1;
          cfgRdata  = cfgAddr ^ RD_KEY;
          seenAddr  = cfgAddr;
          seenWrite = cfgWrite;
          seenBe    = cfgBe;
          seenWdata = cfgWdata;
          waitCnt   = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic access(input logic sel, input logic wr, input logic [WIN_W-1:0] addr,
                        input logic [3:0] be, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    hostValid = 1'b1; hostSel = sel; hostWrite = wr;
    hostAddr = addr; hostBe = be; hostWdata = wd;
    stalls = 0;
    forever begin
      #1;
      if (hostReady) break;
      stalls++;
      @(negedge clk);
    end
    rd = hostRdata;
    @(posedge clk);
    #1 hostValid = 1'b0;
  endtask

  task automatic dataAccess(input logic [31:0] idx, input logic wr,
                            input logic [WIN_W-1:0] off, input logic [3:0] be,
                            input logic [31:0] wd, input int dly, input string tag);
    logic [31:0] rd, exp;
    int st;
    access(1'b0, 1'b1, '0, 4'hF, idx, rd, st);
    respDelay = dly;
    exp = refAddr(idx, off[2:0]);
    access(1'b1, wr, off, be, wd, rd, st);
    check(seenAddr === exp, tag, seenAddr, exp);
    check(seenWrite === wr && seenBe === be, "R7 write/be", {27'b0, seenWrite, seenBe}, {27'b0, wr, be});
    if (wr) check(seenWdata === wd, "R7 wdata", seenWdata, wd);
    else    check(rd === (exp ^ RD_KEY), "R8 rdata", rd, exp ^ RD_KEY);
    check(st == dly + 1, "R9 stall cycles", 32'(st), 32'(dly + 1));
  endtask

  initial begin
    logic [31:0] rd;
    int st;
    int expStarts;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset value and read of other offset.
    access(1'b0, 1'b0, '0, 4'hF, '0, rd, st);
    check(rd === 32'h0, "R1 reset index", rd, 32'h0);
    check(st == 0, "R1 index no stall", 32'(st), 0);
    access(1'b0, 1'b1, '0, 4'hF, 32'hCAFE_0101, rd, st);
    access(1'b0, 1'b0, 12'h004, 4'hF, '0, rd, st);
    check(rd === 32'h0, "R1 other offset", rd, 32'h0);

    // R2 partial byte enables and nonzero offset ignored.
    access(1'b0, 1'b1, '0, 4'h7, 32'h1111_1111, rd, st);
    access(1'b0, 1'b1, 12'h008, 4'hF, 32'h2222_2222, rd, st);
    access(1'b0, 1'b0, '0, 4'hF, '0, rd, st);
    check(rd === 32'hCAFE_0101, "R2 ignored writes", rd, 32'hCAFE_0101);

    expStarts = reqStarts;
    // Directed corner cases.
    dataAccess(32'h8000_1234, 1'b0, 12'h007, 4'hF, '0, 0, "R3 bypass");
    dataAccess(32'h0012_3455, 1'b0, 12'h006, 4'hF, '0, 1, "R4 type1");
    dataAccess(32'h0000_0800 | 32'h0000_05A8, 1'b1, 12'h003, 4'h1, 32'hDEAD_BEEF, 0, "R5 dev0");
    dataAccess(32'h4000_0000, 1'b0, 12'h001, 4'hF, '0, 2, "R5 top select");
    dataAccess(32'h7FF0_8000 | 32'h0000_0300, 1'b1, 12'h004, 4'hC, 32'h0BAD_F00D, 0, "R5 lowest wins");
    dataAccess(32'h0000_07FC, 1'b0, 12'hFFF, 4'hF, '0, 5, "R6 no select");
    expStarts += 6;

    // Random mix.
    for (int i = 0; i < 150; i++) begin
      logic [31:0] idx;
      int form;
      form = $urandom_range(0, 3);
      idx = $urandom;
      case (form)
        0: idx[31] = 1'b1;
        1: begin idx[31] = 1'b0; idx[0] = 1'b1; end
        2: begin
          int lo;
          lo = $urandom_range(11, 30);
          idx[31] = 1'b0; idx[0] = 1'b0;
          for (int b = 11; b < lo; b++) idx[b] = 1'b0;
          idx[lo] = 1'b1;
        end
        default: begin idx[31:11] = '0; idx[0] = 1'b0; end
      endcase
      dataAccess(idx, 1'($urandom), 12'($urandom), 4'($urandom_range(1, 15)),
                 $urandom, $urandom_range(0, 6), form == 3 ? "R6 random" : "R5 random");
      expStarts++;
    end
    check(reqStarts == expStarts, "R9 one request per access", 32'(reqStarts), 32'(expStarts));
    check(holdErrs == 0, "R7 address hold", 32'(holdErrs), 0);

    // R10 interrupt swizzle.
    for (int b = 0; b < 4*NUM_SLOTS; b++) begin
      @(negedge clk);
      slotIrq = '0; slotIrq[b] = 1'b1;
      #1 check(irqOut === refIrq(slotIrq), "R10 single pin", {28'b0, irqOut}, {28'b0, refIrq(slotIrq)});
    end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      slotIrq = (4*NUM_SLOTS)'($urandom);
      #1 check(irqOut === refIrq(slotIrq), "R10 random pins", {28'b0, irqOut}, {28'b0, refIrq(slotIrq)});
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule